// File: doc/BRIEF.md
# Clocked Serial Slave with Ready Handshake

This block is an 8-bit shift interface that serves as a slave to an external master. The master supplies the serial clock. A CPU holds the byte as two 4-bit nibbles on a narrow register bus. The CPU picks the bit order (least or most significant bit first) and the clock polarity, then loads the byte and arms a transfer with a trigger write. The incoming serial clock and data pass through a synchronizer into the system clock domain. Edges are detected there. Each leading edge (inactive to active level) drives the next bit onto the serial output. Each trailing edge samples the serial input into the far end of the shift chain.

A ready output tells the master that the slave is armed. Software must set both a chip-select enable and a ready enable before this output shows anything other than its idle level. With positive polarity the idle level is low and the armed level is high. With negative polarity both levels are inverted. The ready flag is set by the trigger write. It drops back to idle as soon as the synchronized serial clock is first seen at its active level. Any read or write of the upper data nibble also drops it.

After eight trailing edges the busy flag clears and a done flag sets. The received byte can then be read from the same two nibble registers.

Top module: `ss_slave_top`

## Requirements
- R1: After reset, the serial output is 0, the ready output is 0, and all four register addresses read 0.
- R2: Address 0 reads and writes data bits 3:0 and address 1 reads and writes data bits 7:4 (4-bit bus).
- R3: Configuration is at address 3: bit0 selects most-significant-first order, bit1 selects negative polarity, bit2 is chip-select enable and bit3 is ready enable. Status is read at address 2: bit0 is busy and bit1 is done.
- R4: Writing 1 to bit0 of address 2 starts a transfer. In least-significant-first order, data bit k appears on the serial output after leading edge k (k = 0..7).
- R5: In most-significant-first order, data bit 7-k appears on the serial output after leading edge k.
- R6: The bit sampled at trailing edge k lands in data bit k in least-significant-first order and in data bit 7-k in most-significant-first order.
- R7: After the eighth trailing edge, busy reads 0 and done reads 1. During the transfer, busy reads 1 and done reads 0.
- R8: Serial clock edges while not busy leave the stored data unchanged.
- R9: With both enables set and positive polarity, the ready output is 1 in the cycle right after the trigger write. It returns to 0 once the synchronized serial clock is seen at 1, which happens within four system clocks of the pin change and not within one.
- R10: With negative polarity, the ready output idles at 1, goes to 0 after the trigger, and returns to 1 once the serial clock is seen at 0.
- R11: A read or a write of address 1 returns an armed ready output to idle. Accesses to address 0 do not.
- R12: If either enable is 0, the ready output stays at the idle level for the current polarity, even after a trigger.
- R13: Changing the bit order does not reorder data that is already stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 2 | Register address (0 low nibble, 1 high nibble, 2 control/status, 3 configuration) |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (only side effect: address 1 read clears ready) |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data for the selected address |
| sclk_in | input | 1 | Serial clock from the master |
| sin_in | input | 1 | Serial data from the master |
| sout | output | 1 | Serial data to the master |
| srdy | output | 1 | Ready indication to the master |

## Verification
The shift path is tested with every byte value, in both bit orders and both clock polarities. Each transmitted byte is paired with a received byte built from it by inversion and rotation, so a swapped order, a misplaced input bit or an off-by-one count each gives a distinct mismatch. The ready output is tested under each enable combination and both polarities. The tests cover all three clear conditions: the first active clock level, a high-nibble read and a high-nibble write. Low-nibble accesses are tested as the case that must not clear it. Further checks cover clock edges while idle and a bit-order change after loading, both compared against the stored byte.

// File: rtl/ss_pkg.sv
// Package: shared register map and configuration layout for the serial slave.
// Assumes a bus at least 4 bits wide, so the whole configuration fits one word.
package ss_pkg;

    typedef enum logic [1:0] {
        SEL_LO   = 2'd0,
        SEL_HI   = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_CFG  = 2'd3
    } ss_sel_e;

    // Bit order of this struct is the bit order of the configuration register.
    typedef struct packed {
        logic rdy_en;
        logic cs_en;
        logic neg_pol;
        logic msb_first;
    } ss_cfg_t;

    localparam int CFG_W = $bits(ss_cfg_t);

endpackage

// File: rtl/ss_sync.sv
// Multi-stage synchronizer for one asynchronous input.
// Assumes STAGES >= 2. The reset value of the chain is 0.
module ss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One flop stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[g] <= 1'b0;
                else if (g == 0)
                    chain[g] <= d_in;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/ss_edge.sv
// Turns the synchronized serial clock into leading/trailing edge pulses.
// A leading edge moves from the inactive to the active level, and the
// active level is 1 for positive polarity and 0 for negative polarity.
// Assumes sclk_s is already in the system clock domain.
module ss_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic neg_pol,
    output logic at_active,
    output logic lead,
    output logic trail
);
    logic sclk_q;

    // Keeps the previous synchronized level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sclk_q <= 1'b0;
        else
            sclk_q <= sclk_s;
    end

    // Classifies the level and any change against the polarity.
    always_comb begin
        at_active = sclk_s ^ neg_pol;
        lead      = (sclk_s != sclk_q) && at_active;
        trail     = (sclk_s != sclk_q) && !at_active;
    end

    a_r4_edges_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lead && trail));
endmodule

// File: rtl/ss_shift.sv
// Data register and shift engine. It holds the byte, which the CPU loads
// nibble by nibble. The output bit is updated on leading edges. The input
// bit is shifted in on trailing edges, and only while a transfer is busy.
// The order flag picks which end is the head; stored data is never reordered.
module ss_shift #(
    parameter int NIB_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msb_first,
    input  logic               busy,
    input  logic               start,
    input  logic               lead,
    input  logic               trail,
    input  logic               sin_s,
    input  logic               load_lo,
    input  logic               load_hi,
    input  logic [NIB_W-1:0]   wdata,
    output logic [2*NIB_W-1:0] data,
    output logic               sout,
    output logic               last_bit
);
    localparam int DATA_W = 2 * NIB_W;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    logic [CNT_W-1:0] cnt;
    logic             head;
    logic             shift_en;

    // Selects the head bit and gates shifting on an active transfer.
    always_comb begin
        head     = msb_first ? data[DATA_W-1] : data[0];
        shift_en = busy && trail && (cnt < CNT_W'(DATA_W));
        last_bit = shift_en && (cnt == CNT_W'(DATA_W - 1));
    end

    // Data register: CPU nibble loads take priority over shifting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data <= '0;
        else if (load_lo || load_hi) begin
            if (load_lo) data[NIB_W-1:0]      <= wdata;
            if (load_hi) data[DATA_W-1:NIB_W] <= wdata;
        end else if (shift_en) begin
            if (msb_first)
                data <= {data[DATA_W-2:0], sin_s};
            else
                data <= {sin_s, data[DATA_W-1:1]};
        end
    end

    // Bit counter: cleared on start, advanced on each trailing-edge shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= '0;
        else if (shift_en)
            cnt <= cnt + CNT_W'(1);
    end

    // Output latch: takes the head bit on each leading edge of a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sout <= 1'b0;
        else if (busy && lead)
            sout <= head;
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DATA_W));
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !load_lo && !load_hi) |=> $stable(data));
endmodule

// File: rtl/ss_ready.sv
// Ready flag for the external master. A trigger sets it. It clears on the
// first active serial clock level or on any access to the high nibble.
// A trigger wins over a clear in the same cycle. Polarity and the enables
// are applied outside this module.
module ss_ready (
    input  logic clk,
    input  logic rst_n,
    input  logic trigger,
    input  logic hi_access,
    input  logic at_active,
    output logic armed
);
    // Arms on a trigger and disarms on a clear condition.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (trigger)
            armed <= 1'b1;
        else if (hi_access || at_active)
            armed <= 1'b0;
    end

    a_r9_arm: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |=> armed);
    a_r11_hi_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_access && !trigger) |=> !armed);
    a_r9_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && at_active && !trigger) |=> !armed);
endmodule

// File: rtl/ss_slave_top.sv
// Top of the clocked serial slave. It decodes the register bus,
// holds the configuration and the busy/done state, and drives the ready
// output at the level the polarity and enables select.
// Assumes a one-cycle access per strobe and a serial clock far slower than clk.
module ss_slave_top
    import ss_pkg::*;
#(
    parameter int NIB_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [NIB_W-1:0] bus_wdata,
    output logic [NIB_W-1:0] bus_rdata,
    input  logic             sclk_in,
    input  logic             sin_in,
    output logic             sout,
    output logic             srdy
);
    localparam int DATA_W = 2 * NIB_W;

    ss_cfg_t           cfg;
    logic              busy, done;
    logic              sclk_s, sin_s;
    logic              at_active, lead, trail;
    logic              trigger, hi_access, load_lo, load_hi;
    logic              last_bit, armed;
    logic [DATA_W-1:0] data;

    // Bus decode for strobes addressed to each register.
    always_comb begin
        load_lo   = bus_wr && (bus_sel == SEL_LO);
        load_hi   = bus_wr && (bus_sel == SEL_HI);
        hi_access = (bus_wr || bus_rd) && (bus_sel == SEL_HI);
        trigger   = bus_wr && (bus_sel == SEL_CTRL) && bus_wdata[0];
    end

    // Configuration register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (bus_wr && (bus_sel == SEL_CFG))
            cfg <= ss_cfg_t'(bus_wdata[CFG_W-1:0]);
    end

    // Transfer state: a trigger starts it, the last shifted bit ends it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            done <= 1'b0;
        end else if (trigger) begin
            busy <= 1'b1;
            done <= 1'b0;
        end else if (last_bit) begin
            busy <= 1'b0;
            done <= 1'b1;
        end
    end

    // Read mux for the selected register.
    always_comb begin
        bus_rdata = '0;
        case (ss_sel_e'(bus_sel))
            SEL_LO:   bus_rdata = data[NIB_W-1:0];
            SEL_HI:   bus_rdata = data[DATA_W-1:NIB_W];
            SEL_CTRL: bus_rdata[1:0] = {done, busy};
            SEL_CFG:  bus_rdata[CFG_W-1:0] = cfg;
            default:  bus_rdata = '0;
        endcase
    end

    // Ready output: armed level only with both enables set, else idle.
    always_comb begin
        srdy = (armed && cfg.cs_en && cfg.rdy_en) ^ cfg.neg_pol;
    end

    ss_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk (
        .clk(clk), .rst_n(rst_n), .d_in(sclk_in), .d_out(sclk_s)
    );

    ss_sync #(.STAGES(SYNC_STAGES)) u_sync_sin (
        .clk(clk), .rst_n(rst_n), .d_in(sin_in), .d_out(sin_s)
    );

    ss_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .neg_pol(cfg.neg_pol),
        .at_active(at_active), .lead(lead), .trail(trail)
    );

    ss_shift #(.NIB_W(NIB_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .msb_first(cfg.msb_first), .busy(busy),
        .start(trigger), .lead(lead), .trail(trail), .sin_s(sin_s),
        .load_lo(load_lo), .load_hi(load_hi), .wdata(bus_wdata),
        .data(data), .sout(sout), .last_bit(last_bit)
    );

    ss_ready u_ready (
        .clk(clk), .rst_n(rst_n), .trigger(trigger), .hi_access(hi_access),
        .at_active(at_active), .armed(armed)
    );

    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r7_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (last_bit && !trigger) |=> (done && !busy));
    a_r12_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg.cs_en && cfg.rdy_en) |-> (srdy == cfg.neg_pol));
endmodule

// File: tb/sim_ss_slave_top.sv
// Sweeps all byte values through both bit orders and both polarities and
// checks the ready output's set and clear conditions. Expected values are
// computed from the requirements.
module sim_ss_slave_top;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD       = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_sel = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_wdata = 4'd0;
    logic [3:0] bus_rdata;
    logic       sclk_in = 1'b0;
    logic       sin_in = 1'b0;
    logic       sout;
    logic       srdy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ss_slave_top u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_in(sclk_in), .sin_in(sin_in), .sout(sout), .srdy(srdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] d);
        @(negedge clk);
        bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [3:0] d);
        @(negedge clk);
        bus_sel = sel; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_byte(output logic [7:0] b);
        logic [3:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        b = {hi, lo};
    endtask

    // One transfer: loads tx, triggers, clocks 8 bits and returns what was seen.
    task automatic xfer(input logic [7:0] tx, input logic [7:0] rx,
                        input bit msb, input bit neg,
                        output logic [7:0] got_tx, output logic [7:0] got_rx,
                        output logic [3:0] st_mid, output logic [3:0] st_end);
        logic act;
        act = ~neg;
        wr(2'd0, tx[3:0]);
        wr(2'd1, tx[7:4]);
        wr(2'd2, 4'h1);
        got_tx = '0;
        st_mid = '0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            sclk_in = act;
            sin_in  = msb ? rx[7-k] : rx[k];
            idle(HOLD);
            if (msb) got_tx[7-k] = sout; else got_tx[k] = sout;
            if (k == 3) rd(2'd2, st_mid);
            @(negedge clk);
            sclk_in = ~act;
            idle(HOLD);
        end
        rd(2'd2, st_end);
        rd_byte(got_rx);
    endtask

    initial begin
        logic [3:0] r;
        logic [7:0] b, gt, gr, rx;
        logic [3:0] sm, se;
        int tx_bad, rx_bad, st_bad;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(sout == 1'b0, "R1 sout", sout, 0);
        chk(srdy == 1'b0, "R1 srdy", srdy, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            chk(r == 4'h0, "R1 register", r, 0);
        end

        // R2: nibble placement
        wr(2'd0, 4'h6); wr(2'd1, 4'hC);
        rd_byte(b);
        chk(b == 8'hC6, "R2 nibbles", b, 8'hC6);

        // R3: configuration readback
        wr(2'd3, 4'hA);
        rd(2'd3, r);
        chk(r == 4'hA, "R3 config", r, 4'hA);

        // R13: order change keeps stored data
        wr(2'd3, 4'h1);
        rd_byte(b);
        chk(b == 8'hC6, "R13 order change", b, 8'hC6);
        wr(2'd3, 4'h0);
        rd_byte(b);
        chk(b == 8'hC6, "R13 order change back", b, 8'hC6);

        // R4 R5 R6 R7: sweep of every byte, both orders and both polarities
        for (int pol = 0; pol < 2; pol++) begin
            for (int msb = 0; msb < 2; msb++) begin
                wr(2'd3, 4'(msb | (pol << 1)));
                @(negedge clk);
                sclk_in = pol[0];
                idle(HOLD);
                tx_bad = 0; rx_bad = 0; st_bad = 0;
                for (int v = 0; v < 256; v++) begin
                    rx = ~{v[4:0], v[7:5]};
                    xfer(8'(v), rx, msb[0], pol[0], gt, gr, sm, se);
                    if (gt != 8'(v)) begin
                        tx_bad++;
                        if (tx_bad == 1)
                            chk(0, msb ? "R5 tx order" : "R4 tx order", gt, v);
                    end
                    if (gr != rx) begin
                        rx_bad++;
                        if (rx_bad == 1) chk(0, "R6 rx order", gr, rx);
                    end
                    if (sm[1:0] != 2'b01 || se[1:0] != 2'b10) begin
                        st_bad++;
                        if (st_bad == 1) chk(0, "R7 busy/done", {sm, se}, 8'h12);
                    end
                end
                if (tx_bad == 0) chk(1, msb ? "R5" : "R4", 0, 0);
                if (rx_bad == 0) chk(1, "R6", 0, 0);
                if (st_bad == 0) chk(1, "R7", 0, 0);
            end
        end

        // R8: edges while idle leave data unchanged
        wr(2'd3, 4'h0);
        @(negedge clk); sclk_in = 1'b0; idle(HOLD);
        wr(2'd0, 4'h3); wr(2'd1, 4'h9);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            sclk_in = ~sclk_in; sin_in = k[0];
            idle(HOLD);
        end
        sclk_in = 1'b0; idle(HOLD);
        rd_byte(b);
        chk(b == 8'h93, "R8 idle edges", b, 8'h93);

        // R9: positive polarity arm and clear on active level
        wr(2'd3, 4'hC);
        chk(srdy == 1'b0, "R9 idle low", srdy, 0);
        wr(2'd2, 4'h1);
        chk(srdy == 1'b1, "R9 armed", srdy, 1);
        @(negedge clk); sclk_in = 1'b1;
        @(negedge clk);
        chk(srdy == 1'b1, "R9 not yet cleared", srdy, 1);
        idle(HOLD);
        chk(srdy == 1'b0, "R9 cleared by sclk", srdy, 0);
        @(negedge clk); sclk_in = 1'b0; idle(HOLD);

        // R11: low nibble access keeps it, high nibble read clears it
        wr(2'd2, 4'h1);
        wr(2'd0, 4'h5);
        rd(2'd0, r);
        chk(srdy == 1'b1, "R11 low access keeps", srdy, 1);
        rd(2'd1, r);
        chk(srdy == 1'b0, "R11 high read clears", srdy, 0);
        wr(2'd2, 4'h1);
        wr(2'd1, 4'h2);
        chk(srdy == 1'b0, "R11 high write clears", srdy, 0);

        // R10: negative polarity
        wr(2'd3, 4'hE);
        @(negedge clk); sclk_in = 1'b1; idle(HOLD);
        chk(srdy == 1'b1, "R10 idle high", srdy, 1);
        wr(2'd2, 4'h1);
        chk(srdy == 1'b0, "R10 armed low", srdy, 0);
        @(negedge clk); sclk_in = 1'b0;
        idle(HOLD);
        chk(srdy == 1'b1, "R10 cleared by sclk low", srdy, 1);
        @(negedge clk); sclk_in = 1'b1; idle(HOLD);

        // R12: either enable missing keeps the idle level
        wr(2'd3, 4'h6);
        wr(2'd2, 4'h1);
        chk(srdy == 1'b1, "R12 no ready enable, neg", srdy, 1);
        @(negedge clk); sclk_in = 1'b0; idle(HOLD);
        wr(2'd3, 4'h8);
        wr(2'd2, 4'h1);
        chk(srdy == 1'b0, "R12 no cs enable, pos", srdy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule